// File: doc/BRIEF.md
# Signed 64-by-32 divide unit

This unit carries out signed fixed-point division for a CPU execution stage. The dividend is a 64-bit two's-complement number assembled from a register pair: the high word comes from the even register and the low word from the odd register that follows it. The divisor is a 32-bit two's-complement number. The unit returns a 32-bit signed quotient and a 32-bit signed remainder. These are meant for the odd register and the even register of the pair, respectively.

The execution stage sends one pulse on `start` together with the pair number and the operands. The unit captures the operands in that cycle. The stage then waits for the one-cycle `done` pulse, which comes with a status code.

- An odd pair number gives a specification status. The operands are not looked at.
- A zero divisor gives a divide status.
- A quotient that does not fit a 32-bit signed integer also gives a divide status.

`result_wr` rises only on a clean result. In the two early cases, `done` comes in the cycle right after `start`. A full divide needs one load cycle, then 64 iteration cycles, then one sign-fixup cycle. During those cycles a new `start` is ignored.

Top module: `sdiv_unit`

## Requirements
- R1: After reset, `busy`, `done` and `result_wr` are low, `status` is 0, and `quotient` and `remainder` are zero.
- R2: When `start` is accepted with an odd `pair_idx`, `done` is high in the next cycle with `status` = 1 (specification). This holds whatever the operand values are, including a zero divisor. `quotient` and `remainder` are zero.
- R3: When `start` is accepted with an even `pair_idx` and a zero divisor, `done` is high in the next cycle with `status` = 2 (divide exception). This includes a zero dividend.
- R4: A divide that is not rejected early keeps `busy` high from the cycle after `start` until `done` rises. `done` rises in the 66th cycle after the `start` cycle, is high for one cycle, and is never high together with `busy`.
- R5: The quotient is truncated toward zero. It is negative exactly when one operand is negative and the quotient is not zero.
- R6: The remainder has the sign of the dividend. A zero quotient or a zero remainder is reported as +0.
- R7: The dividend's sign is bit 31 of `dividend_hi` alone, so 0x00000000_FFFFFFFF is positive. Divided by 1, it gives status 2.
- R8: A quotient above +2^31-1 or below -2^31 gives status 2 with `quotient` and `remainder` zero. Examples are 0xFFFFFFFF_80000000 divided by -1 and -2^63 divided by -1.
- R9: A quotient of exactly -2^31 is valid and is returned as 0x80000000 with status 0.
- R10: A `start` pulse while `busy` is high is ignored. The running divide finishes with its own operands, and no extra `done` follows.
- R11: `result_wr` is high only in a `done` cycle whose `status` is 0, and it is high in every such cycle.
- R12: Operands are captured in the `start` cycle. Changes to them afterwards do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one divide; accepted when not busy |
| pair_idx | input | REG_IDX_W | Register number of the dividend pair; must be even |
| dividend_hi | input | XLEN | High word of the dividend (even register) |
| dividend_lo | input | XLEN | Low word of the dividend (odd register) |
| divisor | input | XLEN | Signed divisor |
| busy | output | 1 | A divide is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 specification exception, 2 divide exception |
| result_wr | output | 1 | Write enable for the quotient and remainder |
| quotient | output | XLEN | Signed quotient, zero on any exception |
| remainder | output | XLEN | Signed remainder, zero on any exception |

## Verification
The bench builds the unit with its default widths: a 32-bit word and a 4-bit pair number. This puts the exact 2^31 boundaries within direct reach: the unsigned-looking low word, +2^31 that must fail, and -2^31 that must pass. It also reaches the extreme dividend -2^63 and the full 66-cycle latency, so an off-by-one in the iteration count shows up as a latency or value error. A scoreboard model computes each expected quotient and remainder with 128-bit signed arithmetic, independently of the shift-subtract loop. The bench also disturbs the operands and `start` in the middle of a divide to test capture and the rule that `start` is ignored while busy.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    typedef enum logic [1:0] {
        DS_OK    = 2'd0,
        DS_SPEC  = 2'd1,
        DS_FPDIV = 2'd2
    } div_status_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIX  = 2'd2
    } div_phase_e;

endpackage

// File: rtl/sdiv_operand_prep.sv
module sdiv_operand_prep #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   opa_hi,
    input  logic [XLEN-1:0]   opa_lo,
    input  logic [XLEN-1:0]   opb,
    output logic [2*XLEN-1:0] opa_mag,
    output logic [XLEN-1:0]   opb_mag,
    output logic              quo_neg,
    output logic              rem_neg,
    output logic              opb_zero
);
    logic [2*XLEN-1:0] opa_full;

    always_comb begin
        opa_full = {opa_hi, opa_lo};
        // the dividend sign lives only in the top bit of the high word
        rem_neg  = opa_hi[XLEN-1];
        quo_neg  = opa_hi[XLEN-1] ^ opb[XLEN-1];
        opa_mag  = rem_neg ? (~opa_full + 1'b1) : opa_full;
        opb_mag  = opb[XLEN-1] ? (~opb + 1'b1) : opb;
        opb_zero = (opb == '0);
    end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   part_rem,
    input  logic [2*XLEN-1:0] quo_in,
    input  logic [XLEN-1:0]   dsor,
    output logic [XLEN-1:0]   part_rem_nx,
    output logic [2*XLEN-1:0] quo_nx
);
    logic [XLEN:0] shifted;
    logic          fits;

    always_comb begin
        shifted = {part_rem, quo_in[2*XLEN-1]};
        fits    = (shifted >= {1'b0, dsor});
        // the true difference is below dsor, so XLEN bits hold it
        part_rem_nx = fits ? (shifted[XLEN-1:0] - dsor) : shifted[XLEN-1:0];
        quo_nx      = {quo_in[2*XLEN-2:0], fits};
    end
endmodule

// File: rtl/sdiv_result_fix.sv
module sdiv_result_fix #(
    parameter int XLEN = 32
) (
    input  logic [2*XLEN-1:0] quo_mag,
    input  logic [XLEN-1:0]   rem_mag,
    input  logic              quo_neg,
    input  logic              rem_neg,
    output logic [XLEN-1:0]   quo_out,
    output logic [XLEN-1:0]   rem_out,
    output logic              ovf
);
    logic upper_any;
    logic low_any;

    always_comb begin
        upper_any = |quo_mag[2*XLEN-1:XLEN];
        low_any   = |quo_mag[XLEN-2:0];
        if (quo_neg) begin
            // magnitude up to exactly 2^(XLEN-1) is representable
            ovf = upper_any | (quo_mag[XLEN-1] & low_any);
        end else begin
            ovf = upper_any | quo_mag[XLEN-1];
        end
        // negating zero keeps zero, so both results stay +0
        quo_out = quo_neg ? (~quo_mag[XLEN-1:0] + 1'b1) : quo_mag[XLEN-1:0];
        rem_out = rem_neg ? (~rem_mag + 1'b1) : rem_mag;
    end
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit #(
    parameter int XLEN      = 32,
    parameter int REG_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [REG_IDX_W-1:0] pair_idx,
    input  logic [XLEN-1:0]      dividend_hi,
    input  logic [XLEN-1:0]      dividend_lo,
    input  logic [XLEN-1:0]      divisor,
    output logic                 busy,
    output logic                 done,
    output logic [1:0]           status,
    output logic                 result_wr,
    output logic [XLEN-1:0]      quotient,
    output logic [XLEN-1:0]      remainder
);
    import sdiv_pkg::*;

    localparam int STEPS = 2 * XLEN;
    localparam int CNT_W = $clog2(STEPS);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);
    localparam logic [REG_IDX_W-1:0] IDX_ONE = REG_IDX_W'(1);

    typedef struct packed {
        div_phase_e        phase;
        logic [CNT_W-1:0]  cnt;
        logic [XLEN-1:0]   prem;
        logic [STEPS-1:0]  quo;
        logic [XLEN-1:0]   dsor;
        logic              qneg;
        logic              rneg;
        logic              done;
        div_status_e       stat;
        logic [XLEN-1:0]   qres;
        logic [XLEN-1:0]   rres;
    } div_state_t;

    div_state_t st_d, st_q;

    logic [STEPS-1:0] opa_mag;
    logic [XLEN-1:0]  opb_mag;
    logic             quo_neg, rem_neg, opb_zero;
    logic [XLEN-1:0]  step_rem;
    logic [STEPS-1:0] step_quo;
    logic [XLEN-1:0]  fix_q, fix_r;
    logic             fix_ovf;
    logic             pair_odd;

    assign pair_odd = ((pair_idx & IDX_ONE) != '0);

    sdiv_operand_prep #(.XLEN(XLEN)) u_prep (
        .opa_hi   (dividend_hi),
        .opa_lo   (dividend_lo),
        .opb      (divisor),
        .opa_mag  (opa_mag),
        .opb_mag  (opb_mag),
        .quo_neg  (quo_neg),
        .rem_neg  (rem_neg),
        .opb_zero (opb_zero)
    );

    sdiv_step #(.XLEN(XLEN)) u_step (
        .part_rem    (st_q.prem),
        .quo_in      (st_q.quo),
        .dsor        (st_q.dsor),
        .part_rem_nx (step_rem),
        .quo_nx      (step_quo)
    );

    sdiv_result_fix #(.XLEN(XLEN)) u_fix (
        .quo_mag (st_q.quo),
        .rem_mag (st_q.prem),
        .quo_neg (st_q.qneg),
        .rem_neg (st_q.rneg),
        .quo_out (fix_q),
        .rem_out (fix_r),
        .ovf     (fix_ovf)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.qres = '0;
                    st_d.rres = '0;
                    if (pair_odd) begin
                        st_d.done = 1'b1;
                        st_d.stat = DS_SPEC;
                    end else if (opb_zero) begin
                        st_d.done = 1'b1;
                        st_d.stat = DS_FPDIV;
                    end else begin
                        st_d.phase = PH_RUN;
                        st_d.cnt   = '0;
                        st_d.prem  = '0;
                        st_d.quo   = opa_mag;
                        st_d.dsor  = opb_mag;
                        st_d.qneg  = quo_neg;
                        st_d.rneg  = rem_neg;
                    end
                end
            end
            PH_RUN: begin
                st_d.prem = step_rem;
                st_d.quo  = step_quo;
                st_d.cnt  = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST_STEP) begin
                    st_d.phase = PH_FIX;
                end
            end
            PH_FIX: begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
                if (fix_ovf) begin
                    st_d.stat = DS_FPDIV;
                    st_d.qres = '0;
                    st_d.rres = '0;
                end else begin
                    st_d.stat = DS_OK;
                    st_d.qres = fix_q;
                    st_d.rres = fix_r;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.stat  <= DS_OK;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.phase != PH_IDLE);
    assign done      = st_q.done;
    assign status    = st_q.stat;
    assign result_wr = st_q.done && (st_q.stat == DS_OK);
    assign quotient  = st_q.qres;
    assign remainder = st_q.rres;

endmodule

// File: rtl/sdiv_unit_checker.sv
module sdiv_unit_checker #(
    parameter int XLEN      = 32,
    parameter int REG_IDX_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [REG_IDX_W-1:0] pair_idx,
    input logic [XLEN-1:0]      divisor,
    input logic                 busy,
    input logic                 done,
    input logic [1:0]           status,
    input logic                 result_wr,
    input logic [XLEN-1:0]      quotient,
    input logic [XLEN-1:0]      remainder
);
    localparam logic [REG_IDX_W-1:0] IDX_ONE = REG_IDX_W'(1);

    logic odd_req;
    assign odd_req = ((pair_idx & IDX_ONE) != '0);

    // R2: odd pair is rejected in the next cycle, whatever the operands
    assert_spec_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && odd_req) |=> (done && status == 2'd1 && !busy));

    // R3: zero divisor is rejected in the next cycle
    assert_zero_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !odd_req && divisor == '0) |=> (done && status == 2'd2));

    // R4: an accepted divide goes busy
    assert_goes_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !odd_req && divisor != '0) |=> (busy && !done));

    // R4: done is a single-cycle pulse, never together with busy
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: exception results are zero
    assert_exc_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 2'd0) |-> (quotient == '0 && remainder == '0));

    // R11: write enable only with a clean completion
    assert_wr_ok_R11: assert property (@(posedge clk) disable iff (!rst_n)
        result_wr |-> (done && status == 2'd0));
    assert_ok_writes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd0) |-> result_wr);

    // R10: start while busy does not produce an early completion
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && $past(busy)) |=> (busy || done));
endmodule

bind sdiv_unit sdiv_unit_checker #(.XLEN(XLEN), .REG_IDX_W(REG_IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pair_idx  (pair_idx),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .result_wr (result_wr),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/sdiv_unit_test.sv
module sdiv_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  pair_idx = '0;
    logic [31:0] dividend_hi = '0;
    logic [31:0] dividend_lo = '0;
    logic [31:0] divisor = '0;
    logic        busy, done, result_wr;
    logic [1:0]  status;
    logic [31:0] quotient, remainder;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        logic [1:0]  st;
        logic [31:0] q;
        logic [31:0] r;
        int          lat;
        int          start_cyc;
        string       tag;
    } exp_t;

    exp_t sb[$];

    sdiv_unit #(.XLEN(32), .REG_IDX_W(4)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .pair_idx    (pair_idx),
        .dividend_hi (dividend_hi),
        .dividend_lo (dividend_lo),
        .divisor     (divisor),
        .busy        (busy),
        .done        (done),
        .status      (status),
        .result_wr   (result_wr),
        .quotient    (quotient),
        .remainder   (remainder)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [3:0] pr, input logic [31:0] hi,
                                   input logic [31:0] lo, input logic [31:0] dv);
        exp_t e;
        logic signed [127:0] a, b, qq, rr;
        e.q = '0;
        e.r = '0;
        if (pr[0]) begin
            e.st = 2'd1; e.lat = 1;
        end else if (dv == '0) begin
            e.st = 2'd2; e.lat = 1;
        end else begin
            a = {{64{hi[31]}}, hi, lo};
            b = {{96{dv[31]}}, dv};
            qq = a / b;
            rr = a % b;
            e.lat = 66;
            if (qq > 128'sd2147483647 || qq < -128'sd2147483648) begin
                e.st = 2'd2;
            end else begin
                e.st = 2'd0;
                e.q = qq[31:0];
                e.r = rr[31:0];
            end
        end
        return e;
    endfunction

    // driver: pushes the expected item, drives one request, optionally pokes start mid-run
    task automatic run_op(input logic [3:0] pr, input logic [31:0] hi, input logic [31:0] lo,
                          input logic [31:0] dv, input string tag, input bit poke);
        exp_t e;
        e = model(pr, hi, lo, dv);
        e.tag = tag;
        @(negedge clk);
        pair_idx = pr; dividend_hi = hi; dividend_lo = lo; divisor = dv;
        start = 1'b1;
        e.start_cyc = cyc;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        // R12: scramble operands after capture
        pair_idx = 4'd5; dividend_hi = 32'hDEAD_BEEF; dividend_lo = 32'h1234_5678; divisor = 32'd3;
        if (poke) begin
            repeat (10) @(negedge clk);
            // R10: odd pair and zero divisor would both end early if accepted
            start = 1'b1; pair_idx = 4'd3; divisor = '0;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops and compares at every completion
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10", "unexpected done", 64'(done), 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(status == e.st, e.tag, "status", 64'(status), 64'(e.st));
                    check(quotient == e.q, e.tag, "quotient", 64'(quotient), 64'(e.q));
                    check(remainder == e.r, e.tag, "remainder", 64'(remainder), 64'(e.r));
                    check(result_wr == (e.st == 2'd0), {e.tag, " R11"}, "result_wr",
                          64'(result_wr), 64'(e.st == 2'd0));
                    check((cyc - e.start_cyc) == e.lat, {e.tag, " R4"}, "latency",
                          64'(cyc - e.start_cyc), 64'(e.lat));
                end
            end else if (rst_n) begin
                if (result_wr) check(1'b0, "R11", "result_wr without done", 64'(result_wr), 64'd0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(!busy && !done && !result_wr, "R1", "control outputs",
              64'({busy, done, result_wr}), 64'd0);
        check(status == 2'd0 && quotient == '0 && remainder == '0, "R1", "data outputs",
              {30'd0, status, quotient}, 64'd0);

        // R5 R6: sign combinations
        run_op(4'd2, 32'h0, 32'd100, 32'd7, "R5", 1'b0);
        run_op(4'd2, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd7, "R5 R6", 1'b0);
        run_op(4'd4, 32'h0, 32'd100, 32'hFFFF_FFF9, "R5 R6", 1'b0);
        run_op(4'd6, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'hFFFF_FFF9, "R5 R6", 1'b0);
        // R6: zero remainder and zero quotient stay positive
        run_op(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFF2, 32'd7, "R6", 1'b0);
        run_op(4'd0, 32'h0, 32'd3, 32'hFFFF_FFF9, "R6", 1'b0);
        run_op(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFD, 32'd7, "R6", 1'b0);
        // R7: low-word top bit is not a sign
        run_op(4'd2, 32'h0, 32'hFFFF_FFFF, 32'd1, "R7", 1'b0);
        run_op(4'd2, 32'h0, 32'h7FFF_FFFF, 32'd1, "R7", 1'b0);
        // R8: overflow cases
        run_op(4'd8, 32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, "R8", 1'b0);
        run_op(4'd8, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, "R8", 1'b0);
        run_op(4'd8, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R8", 1'b0);
        run_op(4'd8, 32'h8000_0000, 32'h0, 32'd1, "R8", 1'b0);
        // R9: exactly -2^31 fits
        run_op(4'd10, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, "R9", 1'b0);
        run_op(4'd10, 32'h0000_0001, 32'h0, 32'hFFFF_FFFE, "R9", 1'b0);
        // wide valid quotient
        run_op(4'd12, 32'h3FFF_FFFF, 32'h0, 32'h7FFF_FFFF, "R5", 1'b0);
        // R2: odd pair wins over zero divisor
        run_op(4'd3, 32'h0, 32'd0, 32'd0, "R2", 1'b0);
        run_op(4'd15, 32'h0, 32'd100, 32'd7, "R2", 1'b0);
        // R3: zero divisor, including zero dividend
        run_op(4'd2, 32'h0, 32'd0, 32'd0, "R3", 1'b0);
        run_op(4'd2, 32'h0, 32'd5, 32'd0, "R3", 1'b0);
        // R10 R12: start during busy is ignored
        run_op(4'd14, 32'h0, 32'd1000, 32'hFFFF_FFFD, "R10 R12", 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule